// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into memory buffers that software posts as a ring of descriptors. Each descriptor is four 32-bit words. The engine reads a descriptor through a word-wide memory request port. If software has handed the descriptor to the device, the engine packs the incoming bytes into words and writes them to the descriptor's data buffer. When the frame ends, it writes a status word back into the descriptor. That status word returns ownership to software and reports the stored length. The engine then moves on to the next descriptor.

Software controls the engine through a small word register port. The port has a control word with an enable bit, a ring start address, a strobe register that restarts the engine when it is stalled, a write-one-to-clear event register and an interrupt mask. If the engine meets a descriptor that software still holds, it stalls. It raises an event and waits until software writes the restart strobe.

Frame framing, CRC, bus arbitration and transmit are handled elsewhere. Frames arrive as bytes with a valid/ready handshake and a last-byte marker.

Top module: `rxdesc_dma`

## Requirements
- R1: Register 0 bit 0 enables the engine. When it becomes set, the engine fetches its first descriptor at the address held in register 1. A descriptor is four words at consecutive word addresses: word 0 is status with the owner flag in bit 31, word 1 is counts, word 2 is the data buffer address and word 3 is the link address.
- R2: When word 0 has bit 31 clear, the engine writes nothing to memory and deasserts rx_ready. It stalls and sets bit 7 of the event register (register 3).
- R3: While stalled, the engine makes no memory request. A write of any value to register 2 makes it re-read word 0 of the same descriptor, and it goes on if bit 31 is now set.
- R4: Received bytes go to consecutive words starting at the data buffer address, little-endian (first byte in bits 7:0). A final partial word is written with mem_be set only for its filled byte lanes.
- R5: At the end of a frame, the engine writes word 0 of the descriptor as follows: bit 31 is 0, bits 26:16 hold the number of bytes stored, bit 15 is the overflow flag, and all other bits are 0.
- R6: Counts bits 10:0 give the buffer size in bytes. Bytes beyond that size are accepted and dropped. The stored length then equals the size and bit 15 of the status word is set.
- R7: The next descriptor address is chosen as follows. If counts bit 25 is set, it is register 1. Otherwise, if counts bit 24 is set, it is the link word. Otherwise it is the current address plus 16. Bit 25 wins over bit 24.
- R8: Register 3 bit 6 is set each time a status word is written back. Writing a 1 to a bit of register 3 clears that bit, but a new event in the same cycle keeps it set.
- R9: irq is high exactly when a register 3 bit is set together with the same bit of the mask in register 4.
- R10: Once mem_req is raised, it stays high with the same address, direction and data until the cycle in which mem_ack is seen.
- R11: rx_ready is high only while the engine can take a byte. It is low out of reset, while stalled, and while a memory access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| irq | output | 1 | Masked event interrupt |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Byte is the final one of its frame |
| rx_ready | output | 1 | Engine takes the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | DW/8 | Byte lane enables for writes |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The embedded properties watch, on every cycle, that a memory request holds steady until it is acknowledged and that an unowned descriptor always leads straight into the stall. They also check that a written-back length never exceeds the buffer size, that end-of-ring always returns to the start address, and that the event register obeys set-over-clear. What only the scenarios can show is the ring walk across all three link kinds, the byte lanes of partial words, the bytes that overflow drops, and that untouched buffer bytes keep their old contents. The restart after software re-arms a descriptor and the interaction of mask and events on irq are also covered only by the scenarios. A scoreboard compares every memory write the engine makes against writes predicted from the frame and descriptor contents.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

   // descriptor field positions (software and engine both decode these)
   localparam int OWN_BIT   = 31;
   localparam int LEN_LSB   = 16;
   localparam int LEN_W     = 11;
   localparam int OVF_BIT   = 15;
   localparam int LINK_BIT  = 24;
   localparam int WRAP_BIT  = 25;
   localparam int SIZE_W    = 11;
   localparam int DESC_WORDS = 4;

   // register word indices
   localparam int REG_CTRL = 0;
   localparam int REG_BASE = 1;
   localparam int REG_POLL = 2;
   localparam int REG_EVT  = 3;
   localparam int REG_MASK = 4;

   // event bits
   localparam int EV_DONE  = 6;
   localparam int EV_STALL = 7;

   typedef enum logic [3:0] {
      W_OFF,
      W_RD_OWN,
      W_RD_CNT,
      W_RD_BUF,
      W_RD_LNK,
      W_STALL,
      W_RECV,
      W_WR_DATA,
      W_WR_STAT
   } walk_st_t;

endpackage

// File: rtl/rxdma_csr.sv
module rxdma_csr
   import rxdma_pkg::*;
#(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int RA_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   input  logic            evt_done,
   input  logic            evt_stall,
   output logic            rx_en,
   output logic [AW-1:0]   ring_base,
   output logic            poll,
   output logic            irq
);

   localparam logic [DW-1:0] EV_IMPL = (DW'(1) << EV_DONE) | (DW'(1) << EV_STALL);

   if (AW > DW) begin : g_bad_aw
      $error("rxdma_csr: AW must not exceed DW");
   end
   if (RA_W < 3) begin : g_bad_ra
      $error("rxdma_csr: RA_W too small for register map");
   end

   logic            en_q;
   logic [AW-1:0]   base_q;
   logic [DW-1:0]   ev_q;
   logic [DW-1:0]   mask_q;
   logic [DW-1:0]   ev_set;
   logic [DW-1:0]   ev_clr;
   logic            wr_ctrl, wr_base, wr_evt, wr_mask;

   assign wr_ctrl = reg_wr && (reg_addr == RA_W'(REG_CTRL));
   assign wr_base = reg_wr && (reg_addr == RA_W'(REG_BASE));
   assign wr_evt  = reg_wr && (reg_addr == RA_W'(REG_EVT));
   assign wr_mask = reg_wr && (reg_addr == RA_W'(REG_MASK));
   assign poll    = reg_wr && (reg_addr == RA_W'(REG_POLL));

   always_comb begin
      ev_set = '0;
      ev_set[EV_DONE]  = evt_done;
      ev_set[EV_STALL] = evt_stall;
      ev_clr = wr_evt ? reg_wdata : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         base_q <= '0;
         ev_q   <= '0;
         mask_q <= '0;
      end else begin
         if (wr_ctrl) en_q <= reg_wdata[0];
         if (wr_base) base_q <= reg_wdata[AW-1:0] & ~AW'(3);
         if (wr_mask) mask_q <= reg_wdata;
         ev_q <= ((ev_q & ~ev_clr) | ev_set) & EV_IMPL;
      end
   end

   always_comb begin
      case (reg_addr)
         RA_W'(REG_CTRL): reg_rdata = DW'(en_q);
         RA_W'(REG_BASE): reg_rdata = DW'(base_q);
         RA_W'(REG_EVT):  reg_rdata = ev_q;
         RA_W'(REG_MASK): reg_rdata = mask_q;
         default:         reg_rdata = '0;
      endcase
   end

   assign rx_en     = en_q;
   assign ring_base = base_q;
   assign irq       = |(ev_q & mask_q);

   // R8: an event in the same cycle as its clear leaves the bit set
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |=> ev_q[EV_DONE]);

   // R8: writing one with no concurrent event clears the bit
   a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && reg_wdata[EV_STALL] && !evt_stall) |=> !ev_q[EV_STALL]);

endmodule

// File: rtl/rxdma_packer.sv
module rxdma_packer #(
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic [7:0]      byte_in,
   input  logic            clr,
   output logic [DW-1:0]   word,
   output logic [DW/8-1:0] be,
   output logic [$clog2(DW/8+1)-1:0] fill,
   output logic            full
);

   localparam int NB = DW / 8;
   localparam int FW = $clog2(NB + 1);

   if ((DW % 8) != 0 || DW < 16) begin : g_bad_dw
      $error("rxdma_packer: DW must be a multiple of 8, at least 16");
   end

   logic [FW-1:0] fill_q;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic [7:0] lane_q;
      logic       used_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lane_q <= '0;
            used_q <= 1'b0;
         end else if (clr) begin
            used_q <= 1'b0;
         end else if (take && fill_q == FW'(i)) begin
            lane_q <= byte_in;
            used_q <= 1'b1;
         end
      end
      assign word[i*8 +: 8] = lane_q;
      assign be[i]          = used_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    fill_q <= '0;
      else if (clr)  fill_q <= '0;
      else if (take) fill_q <= fill_q + FW'(1);
   end

   assign fill = fill_q;
   assign full = (fill_q == FW'(NB));

   // R11: no byte may be taken into a word that is already full
   a_r11_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !full);

endmodule

// File: rtl/rxdma_walker.sv
module rxdma_walker
   import rxdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_en,
   input  logic [AW-1:0]   ring_base,
   input  logic            poll,
   input  logic            rx_valid,
   input  logic [7:0]      rx_data,
   input  logic            rx_last,
   output logic            rx_ready,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW/8-1:0] mem_be,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_ack,
   input  logic [DW-1:0]   mem_rdata,
   output logic            evt_done,
   output logic            evt_stall
);

   localparam int NB     = DW / 8;
   localparam int FW     = $clog2(NB + 1);
   localparam int DSTEP  = DESC_WORDS * NB;

   if (DW != 32) begin : g_bad_dw
      $error("rxdma_walker: descriptor format needs DW of 32");
   end

   walk_st_t          st_q;
   logic [AW-1:0]     cur_q, buf_q, lnk_q, wptr_q;
   logic [SIZE_W-1:0] size_q;
   logic [LEN_W-1:0]  stored_q;
   logic              link_q, wrap_q, ovf_q, last_q;

   logic              acc, room, pk_take, pk_clr, pk_full;
   logic [DW-1:0]     pk_word;
   logic [NB-1:0]     pk_be;
   logic [FW-1:0]     pk_fill, fill_nx;
   logic [AW-1:0]     next_desc;
   logic [DW-1:0]     wb_word;

   rxdma_packer #(.DW(DW)) i_packer (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (pk_take),
      .byte_in (rx_data),
      .clr     (pk_clr),
      .word    (pk_word),
      .be      (pk_be),
      .fill    (pk_fill),
      .full    (pk_full)
   );

   assign rx_ready = (st_q == W_RECV);
   assign acc      = rx_valid && rx_ready;
   assign room     = (SIZE_W'(stored_q) < size_q);
   assign pk_take  = acc && room;
   assign pk_clr   = (st_q == W_WR_DATA) && mem_ack;
   assign fill_nx  = pk_fill + FW'(pk_take);

   always_comb begin
      if (wrap_q)      next_desc = ring_base;
      else if (link_q) next_desc = lnk_q;
      else             next_desc = cur_q + AW'(DSTEP);
   end

   always_comb begin
      wb_word = '0;
      wb_word[LEN_LSB +: LEN_W] = stored_q;
      wb_word[OVF_BIT]          = ovf_q;
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q;
      mem_be    = '1;
      mem_wdata = '0;
      case (st_q)
         W_RD_OWN:  mem_req = 1'b1;
         W_RD_CNT:  begin mem_req = 1'b1; mem_addr = cur_q + AW'(NB);   end
         W_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_q + AW'(2*NB); end
         W_RD_LNK:  begin mem_req = 1'b1; mem_addr = cur_q + AW'(3*NB); end
         W_WR_DATA: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = wptr_q;
            mem_be    = pk_be;
            mem_wdata = pk_word;
         end
         W_WR_STAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = wb_word;
         end
         default: ;
      endcase
   end

   assign evt_done  = (st_q == W_WR_STAT) && mem_ack;
   assign evt_stall = (st_q == W_RD_OWN) && mem_ack && !mem_rdata[OWN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= W_OFF;
         cur_q    <= '0;
         buf_q    <= '0;
         lnk_q    <= '0;
         wptr_q   <= '0;
         size_q   <= '0;
         stored_q <= '0;
         link_q   <= 1'b0;
         wrap_q   <= 1'b0;
         ovf_q    <= 1'b0;
         last_q   <= 1'b0;
      end else begin
         case (st_q)
            W_OFF: if (rx_en) begin
               cur_q <= ring_base;
               st_q  <= W_RD_OWN;
            end
            W_RD_OWN: if (mem_ack) begin
               st_q <= mem_rdata[OWN_BIT] ? W_RD_CNT : W_STALL;
            end
            W_RD_CNT: if (mem_ack) begin
               size_q <= mem_rdata[SIZE_W-1:0];
               link_q <= mem_rdata[LINK_BIT];
               wrap_q <= mem_rdata[WRAP_BIT];
               st_q   <= W_RD_BUF;
            end
            W_RD_BUF: if (mem_ack) begin
               buf_q  <= mem_rdata[AW-1:0] & ~AW'(NB-1);
               wptr_q <= mem_rdata[AW-1:0] & ~AW'(NB-1);
               st_q   <= W_RD_LNK;
            end
            W_RD_LNK: if (mem_ack) begin
               lnk_q    <= mem_rdata[AW-1:0] & ~AW'(NB-1);
               stored_q <= '0;
               ovf_q    <= 1'b0;
               last_q   <= 1'b0;
               st_q     <= W_RECV;
            end
            W_STALL: begin
               if (!rx_en)    st_q <= W_OFF;
               else if (poll) st_q <= W_RD_OWN;
            end
            W_RECV: if (acc) begin
               if (room) stored_q <= stored_q + LEN_W'(1);
               else      ovf_q    <= 1'b1;
               if (rx_last) begin
                  last_q <= 1'b1;
                  st_q   <= (fill_nx != '0) ? W_WR_DATA : W_WR_STAT;
               end else if (fill_nx == FW'(NB)) begin
                  st_q <= W_WR_DATA;
               end
            end
            W_WR_DATA: if (mem_ack) begin
               wptr_q <= wptr_q + AW'(NB);
               st_q   <= last_q ? W_WR_STAT : W_RECV;
            end
            W_WR_STAT: if (mem_ack) begin
               cur_q <= next_desc;
               st_q  <= rx_en ? W_RD_OWN : W_OFF;
            end
            default: st_q <= W_OFF;
         endcase
      end
   end

   // R10: a pending request keeps its address, direction and data
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata)));

   // R2: a descriptor held by software leads straight into the stall
   a_r2_unowned_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      evt_stall |=> (st_q == W_STALL && !rx_ready));

   // R6: the written-back length never exceeds the buffer size
   a_r6_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == W_WR_STAT) |-> (SIZE_W'(mem_wdata[LEN_LSB +: LEN_W]) <= size_q));

   // R7: end-of-ring returns to the start address
   a_r7_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_done && wrap_q) |=> (cur_q == $past(ring_base)));

endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma
   import rxdma_pkg::*;
#(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int RA_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   output logic            irq,
   input  logic            rx_valid,
   input  logic [7:0]      rx_data,
   input  logic            rx_last,
   output logic            rx_ready,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW/8-1:0] mem_be,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_ack,
   input  logic [DW-1:0]   mem_rdata
);

   logic          rx_en, poll, evt_done, evt_stall;
   logic [AW-1:0] ring_base;

   rxdma_csr #(.AW(AW), .DW(DW), .RA_W(RA_W)) i_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_done  (evt_done),
      .evt_stall (evt_stall),
      .rx_en     (rx_en),
      .ring_base (ring_base),
      .poll      (poll),
      .irq       (irq)
   );

   rxdma_walker #(.AW(AW), .DW(DW)) i_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .ring_base (ring_base),
      .poll      (poll),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_last   (rx_last),
      .rx_ready  (rx_ready),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_be    (mem_be),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .evt_done  (evt_done),
      .evt_stall (evt_stall)
   );

endmodule

// File: tb/test_rxdesc_dma.sv
`timescale 1ns/1ps
module test_rxdesc_dma;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_last = 1'b0;
   logic        rx_ready;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   rxdesc_dma i_rxdesc_dma (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model: one-cycle acknowledge, bench pokes go through the same process
   logic [31:0] mem [0:511];
   logic        poke_en = 1'b0;
   logic [31:0] poke_addr = '0;
   logic [31:0] poke_data = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         for (int i = 0; i < 512; i++) mem[i] <= 32'hAAAA_AAAA;
      end else begin
         if (poke_en) mem[poke_addr[10:2]] <= poke_data;
         if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               for (int l = 0; l < 4; l++)
                  if (mem_be[l]) mem[mem_addr[10:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
            end else begin
               mem_rdata <= mem[mem_addr[10:2]];
            end
         end else begin
            mem_ack <= 1'b0;
         end
      end
   end

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      logic [3:0]  be;
      string       tag;
   } item_t;
   item_t sbq[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: compare each engine write against the predicted one
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_we && mem_ack) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R4", "unexpected write addr", mem_addr, 32'h0);
         end else begin
            item_t e;
            logic [31:0] m;
            e = sbq.pop_front();
            m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
            chk(mem_addr == e.addr, e.tag, "write address", mem_addr, e.addr);
            chk(mem_be == e.be, e.tag, "byte enables", {28'h0, mem_be}, {28'h0, e.be});
            chk((mem_wdata & m) == (e.data & m), e.tag, "write data", mem_wdata & m, e.data & m);
         end
      end
   end

   function automatic logic [7:0] fbyte(input int seed, input int i);
      return 8'(seed * 31 + i * 13 + 5);
   endfunction

   task automatic expect_frame(input logic [31:0] desc, input logic [31:0] bufa,
                               input int n, input int size, input int seed,
                               input string stag);
      int stored;
      item_t it;
      stored = (n < size) ? n : size;
      for (int w = 0; w * 4 < stored; w++) begin
         it.addr = bufa + 32'(w * 4);
         it.data = '0;
         it.be   = '0;
         for (int l = 0; l < 4; l++) begin
            if (w * 4 + l < stored) begin
               it.data[l*8 +: 8] = fbyte(seed, w * 4 + l);
               it.be[l] = 1'b1;
            end
         end
         it.tag = "R4";
         sbq.push_back(it);
      end
      it.addr = desc;
      it.data = (32'(stored) << 16) | ((n > size) ? 32'h8000 : 32'h0);
      it.be   = 4'hF;
      it.tag  = stag;
      sbq.push_back(it);
   endtask

   task automatic send_frame(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1;
         rx_data  = fbyte(seed, i);
         rx_last  = (i == n - 1);
         while (!rx_ready) @(negedge clk);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_last  = 1'b0;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      poke_en = 1'b1; poke_addr = a; poke_data = d;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 2000; i++) begin
         if (sbq.size() == 0) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
      chk(sbq.size() == 0, "R5", "pending predicted writes", 32'(sbq.size()), 32'h0);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=expired expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(irq == 1'b0, "R9", "irq after reset", {31'h0, irq}, 32'h0);
      chk(rx_ready == 1'b0, "R11", "rx_ready after reset", {31'h0, rx_ready}, 32'h0);
      chk(mem_req == 1'b0, "R10", "mem_req after reset", {31'h0, mem_req}, 32'h0);
      rd_reg(3'd3, r);
      chk(r == 32'h0, "R8", "event register after reset", r, 32'h0);

      // ring: 0x100 plain -> 0x110 linked to 0x200 -> 0x200 end of ring
      poke(32'h100, 32'h8000_0000); poke(32'h104, 32'd64);
      poke(32'h108, 32'h400);       poke(32'h10C, 32'h0);
      poke(32'h110, 32'h8000_0000); poke(32'h114, 32'h0100_0006);
      poke(32'h118, 32'h500);       poke(32'h11C, 32'h200);
      poke(32'h200, 32'h8000_0000); poke(32'h204, 32'h0200_0040);
      poke(32'h208, 32'h600);       poke(32'h20C, 32'h0);

      wr_reg(3'd1, 32'h100);
      wr_reg(3'd4, 32'h40);

      // frame 0: 10 bytes, partial last word
      expect_frame(32'h100, 32'h400, 10, 64, 1, "R5");
      wr_reg(3'd0, 32'h1);
      send_frame(10, 1);
      drain();
      chk(mem[32'h400 >> 2] == {fbyte(1,3), fbyte(1,2), fbyte(1,1), fbyte(1,0)}, "R1",
          "first buffer word", mem[32'h400 >> 2], {fbyte(1,3), fbyte(1,2), fbyte(1,1), fbyte(1,0)});
      chk(mem[32'h408 >> 2] == {16'hAAAA, fbyte(1,9), fbyte(1,8)}, "R4",
          "partial word keeps lanes", mem[32'h408 >> 2], {16'hAAAA, fbyte(1,9), fbyte(1,8)});
      chk(mem[32'h100 >> 2] == 32'h000A_0000, "R5", "status word", mem[32'h100 >> 2], 32'h000A_0000);
      rd_reg(3'd3, r);
      chk(r == 32'h40, "R8", "done event", r, 32'h40);
      chk(irq == 1'b1, "R9", "irq with done unmasked", {31'h0, irq}, 32'h1);
      wr_reg(3'd3, 32'h40);
      rd_reg(3'd3, r);
      chk(r == 32'h0, "R8", "write-one clears", r, 32'h0);
      chk(irq == 1'b0, "R9", "irq after clear", {31'h0, irq}, 32'h0);

      // frame 1: 9 bytes into a 6-byte buffer via linked descriptor
      expect_frame(32'h110, 32'h500, 9, 6, 2, "R6");
      send_frame(9, 2);
      drain();
      chk(mem[32'h504 >> 2] == {16'hAAAA, fbyte(2,5), fbyte(2,4)}, "R6",
          "bytes past size dropped", mem[32'h504 >> 2], {16'hAAAA, fbyte(2,5), fbyte(2,4)});
      chk(mem[32'h508 >> 2] == 32'hAAAA_AAAA, "R6", "word past buffer untouched",
          mem[32'h508 >> 2], 32'hAAAA_AAAA);

      // frame 2: follows the link word to 0x200 (R7)
      expect_frame(32'h200, 32'h600, 4, 64, 3, "R7");
      send_frame(4, 3);
      drain();

      // wrap back to 0x100, now owned by software -> stall
      repeat (20) @(negedge clk);
      rd_reg(3'd3, r);
      chk(r == 32'hC0, "R2", "stall event set", r, 32'hC0);
      chk(rx_ready == 1'b0, "R11", "rx_ready while stalled", {31'h0, rx_ready}, 32'h0);
      chk(mem_req == 1'b0, "R2", "no access while stalled", {31'h0, mem_req}, 32'h0);

      wr_reg(3'd4, 32'h80);
      wr_reg(3'd3, 32'h40);
      chk(irq == 1'b1, "R9", "irq from stall event", {31'h0, irq}, 32'h1);
      wr_reg(3'd3, 32'h80);
      chk(irq == 1'b0, "R9", "irq after stall clear", {31'h0, irq}, 32'h0);

      // re-arm 0x100 with a new buffer; nothing happens until the strobe
      poke(32'h100, 32'h8000_0000); poke(32'h104, 32'd32); poke(32'h108, 32'h700);
      repeat (10) @(negedge clk);
      chk(mem_req == 1'b0, "R3", "no re-read before strobe", {31'h0, mem_req}, 32'h0);
      expect_frame(32'h100, 32'h700, 5, 32, 4, "R7");
      wr_reg(3'd2, 32'h0);
      send_frame(5, 4);
      drain();
      chk(mem[32'h704 >> 2] == {24'hAAAAAA, fbyte(4,4)}, "R3",
          "frame after restart", mem[32'h704 >> 2], {24'hAAAAAA, fbyte(4,4)});

      // next descriptor 0x110 is software-owned again
      repeat (20) @(negedge clk);
      rd_reg(3'd3, r);
      chk(r == 32'hC0, "R2", "second stall", r, 32'hC0);

      chk(sbq.size() == 0, "R4", "scoreboard empty at end", 32'(sbq.size()), 32'h0);
      finish_run();
   end

endmodule